// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block is a fully associative address translation buffer whose contents are maintained entirely by system software. Software stages an entry in five holding registers: a tag word, two half-mapping words and a page-size mask, plus a slot register. It then issues one of four commands. An indexed write stores the staged entry at the slot named by the slot register. A victim write stores it at the slot named by a free-running victim counter. A read copies the entry at the slot register back into the holding registers. A probe searches for the current tag and records the result in the slot register.

Each entry maps a pair of adjacent pages, an even page and an odd page, under one tag. The page size is set per entry by the mask. A combinational lookup port takes a virtual address and an address-space identifier. It returns hit or miss and, on a hit, the valid, dirty, cache-attribute and frame-number fields of the selected half. Fault raising, table walking and cache behaviour are left to the surrounding logic.

Top module: `sw_tlb`

## Requirements
- R1: Reset clears every entry to zero, so every valid bit reads 0. Reset sets the victim counter to ENTRIES-1 and the slot register to 0.
- R2: The victim counter decrements by one on every clock edge out of reset, and goes from 0 back to ENTRIES-1.
- R3: Register write selects are 0 tag, 1 even half, 2 odd half, 3 size mask and 4 slot. The tag keeps bits 31:13 (page number) and 7:0 (identifier), and its other bits read 0. Each half word keeps bits 25:0. The mask keeps bits 24:13. The slot register keeps all 32 bits. A register write in a cycle that carries a command is ignored.
- R4: Command codes are 0 indexed write, 1 victim write, 2 read and 3 probe. An indexed write targets slot register bits [log2(ENTRIES)-1:0], with the higher bits dropped. A victim write targets the victim counter value seen at that clock edge.
- R5: A half word has bit 0 global, bit 1 valid, bit 2 dirty, bits 5:3 cache attribute and bits 25:6 frame number (physical address bits 31:12). The stored global flag is the AND of bit 0 of both half words.
- R6: A read loads the tag with page number and identifier, and bits 12:8 read 0. It loads the mask from the stored size, and loads both half words with the stored global flag in bit 0 of each.
- R7: A probe matches an entry whose page number equals tag bits 31:13 exactly and that is global or has an identifier equal to tag bits 7:0. The lowest matching slot is written to the slot register with bit 31 clear.
- R8: A probe that matches nothing sets bit 31 of the slot register and leaves bits 30:0 unchanged.
- R9: A lookup matches an entry that is global or has an identifier equal to the lookup identifier, and whose page number equals address bits 31:13 in every position not set in the entry's mask (mask bit k covers address bit 13+k). The lowest matching slot wins.
- R10: On a lookup hit, address bit 12+n selects the half, where n is the number of set mask bits: 0 selects even, 1 selects odd. The outputs carry that half's valid, dirty, cache attribute and frame number.
- R11: A lookup with no match drives hit, valid, dirty, cache attribute and frame number all to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Holding-register write strobe |
| reg_sel | input | 3 | Register select for the write |
| reg_wdata | input | 32 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| tag_q | output | 32 | Tag holding register |
| even_q | output | 32 | Even-half holding register |
| odd_q | output | 32 | Odd-half holding register |
| mask_q | output | 32 | Size-mask holding register |
| slot_q | output | 32 | Slot register |
| victim_q | output | log2(ENTRIES) | Victim counter |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_valid | output | 1 | Selected half valid |
| lk_dirty | output | 1 | Selected half dirty |
| lk_cattr | output | 3 | Selected half cache attribute |
| lk_pfn | output | 20 | Selected half frame number |

## Verification
The bench installs two entries with the same page number, one private and one global. This shows that the identifier test and lowest-slot priority both apply: a design that picked the highest slot or ignored the global flag would return the wrong frame. An entry with a 16 KB mask is looked up at addresses that differ only in the masked bit 13 and in the select bit 14. A design that chose the half from bit 12, or compared masked bits, would return the wrong half or miss. Probe misses are checked to keep the old slot bits under the new flag bit. An indexed write through an oversized slot value must land in the wrapped slot. A register write issued together with a probe must leave its register untouched.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
  localparam int VPN_W   = 19;
  localparam int ASID_W  = 8;
  localparam int MASK_W  = 12;
  localparam int PFN_W   = 20;
  localparam int CA_W    = 3;
  localparam int PAGE_LSB = 12;
  localparam int VPN_LSB  = 13;
  localparam int PFN_LSB  = 6;

  localparam logic [31:0] TAG_KEEP  = 32'hFFFF_E0FF;
  localparam logic [31:0] HALF_KEEP = 32'h03FF_FFFF;
  localparam logic [31:0] MASK_KEEP = 32'h01FF_E000;
  localparam logic [31:0] MISS_FLAG = 32'h8000_0000;

  typedef enum logic [1:0] {
    OP_WR_SLOT   = 2'd0,
    OP_WR_VICTIM = 2'd1,
    OP_READ      = 2'd2,
    OP_PROBE     = 2'd3
  } tlb_op_e;

  typedef enum logic [2:0] {
    SEL_TAG  = 3'd0,
    SEL_EVEN = 3'd1,
    SEL_ODD  = 3'd2,
    SEL_MASK = 3'd3,
    SEL_SLOT = 3'd4
  } tlb_sel_e;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [CA_W-1:0]  cattr;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [MASK_W-1:0] mask;
    logic              glob;
    half_t             even;
    half_t             odd;
  } entry_t;

  function automatic half_t unpack_half(input logic [31:0] w);
    half_t h;
    h.pfn   = w[PFN_LSB +: PFN_W];
    h.cattr = w[3 +: CA_W];
    h.dirty = w[2];
    h.valid = w[1];
    return h;
  endfunction

  function automatic logic [31:0] pack_half(input half_t h, input logic g);
    return {{(32-PFN_LSB-PFN_W){1'b0}}, h.pfn, h.cattr, h.dirty, h.valid, g};
  endfunction

  function automatic logic tag_match(input logic [VPN_W-1:0] ent_vpn,
                                     input logic [VPN_W-1:0] key_vpn,
                                     input logic [MASK_W-1:0] mask,
                                     input logic use_mask);
    logic [VPN_W-1:0] ignore;
    ignore = use_mask ? {{(VPN_W-MASK_W){1'b0}}, mask} : '0;
    return ((ent_vpn ^ key_vpn) & ~ignore) == '0;
  endfunction

  function automatic logic odd_pick(input logic [31:0] va, input logic [MASK_W-1:0] mask);
    logic [4:0] pos;
    pos = 5'(PAGE_LSB);
    for (int i = 0; i < MASK_W; i++) begin
      if (mask[i]) pos = pos + 5'd1;
    end
    return va[pos];
  endfunction
endpackage

// File: rtl/sw_tlb_victim.sv
module sw_tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] cnt
);
  localparam logic [IW-1:0] TOP = IW'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= TOP;
    else if (cnt == '0)   cnt <= TOP;
    else                  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sw_tlb_store.sv
module sw_tlb_store import sw_tlb_pkg::*; #(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wslot,
  input  entry_t        wentry,
  output entry_t        ents [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                        ents[g] <= '0;
      else if (we && wslot == IW'(g))    ents[g] <= wentry;
    end
  end
endmodule

// File: rtl/sw_tlb_match.sv
module sw_tlb_match import sw_tlb_pkg::*; #(
  parameter int ENTRIES  = 16,
  parameter bit USE_MASK = 1'b1,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]  e_vpn  [ENTRIES],
  input  logic [ASID_W-1:0] e_asid [ENTRIES],
  input  logic [MASK_W-1:0] e_mask [ENTRIES],
  input  logic [ENTRIES-1:0] e_glob,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  logic [ENTRIES-1:0] hits;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = (e_glob[g] || e_asid[g] == asid) &&
                     tag_match(e_vpn[g], vpn, e_mask[g], USE_MASK);
  end

  always_comb begin
    hit = |hits;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb import sw_tlb_pkg::*; #(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [31:0]   lk_vaddr,
  input  logic [7:0]    lk_asid,
  output logic [31:0]   tag_q,
  output logic [31:0]   even_q,
  output logic [31:0]   odd_q,
  output logic [31:0]   mask_q,
  output logic [31:0]   slot_q,
  output logic [IW-1:0] victim_q,
  output logic          lk_hit,
  output logic          lk_valid,
  output logic          lk_dirty,
  output logic [2:0]    lk_cattr,
  output logic [19:0]   lk_pfn
);
  entry_t ents [ENTRIES];
  entry_t new_ent;
  entry_t rd_ent;
  entry_t lk_ent;
  half_t  lk_half;

  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [MASK_W-1:0]  e_mask [ENTRIES];
  logic [ENTRIES-1:0] e_glob;

  // Named internal events, observed by the bound checker
  logic          cmd_write;
  logic [IW-1:0] wr_slot;
  logic          probe_hit;
  logic [IW-1:0] probe_idx;
  logic          lk_match;
  logic [IW-1:0] lk_idx;
  logic          lk_odd;

  sw_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .cnt(victim_q)
  );

  assign cmd_write = cmd_valid &&
                     (cmd_op == OP_WR_SLOT || cmd_op == OP_WR_VICTIM);
  assign wr_slot   = (cmd_op == OP_WR_VICTIM) ? victim_q : slot_q[IW-1:0];

  always_comb begin
    new_ent.vpn  = tag_q[VPN_LSB +: VPN_W];
    new_ent.asid = tag_q[ASID_W-1:0];
    new_ent.mask = mask_q[VPN_LSB +: MASK_W];
    new_ent.glob = even_q[0] & odd_q[0];
    new_ent.even = unpack_half(even_q);
    new_ent.odd  = unpack_half(odd_q);
  end

  sw_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cmd_write), .wslot(wr_slot),
    .wentry(new_ent), .ents(ents)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_fan
    assign e_vpn[g]  = ents[g].vpn;
    assign e_asid[g] = ents[g].asid;
    assign e_mask[g] = ents[g].mask;
    assign e_glob[g] = ents[g].glob;
  end

  // Probe: exact page-number compare against the staged tag
  sw_tlb_match #(.ENTRIES(ENTRIES), .USE_MASK(1'b0)) u_probe (
    .e_vpn(e_vpn), .e_asid(e_asid), .e_mask(e_mask), .e_glob(e_glob),
    .vpn(tag_q[VPN_LSB +: VPN_W]), .asid(tag_q[ASID_W-1:0]),
    .hit(probe_hit), .idx(probe_idx)
  );

  // Lookup: compare honours each entry's size mask
  sw_tlb_match #(.ENTRIES(ENTRIES), .USE_MASK(1'b1)) u_look (
    .e_vpn(e_vpn), .e_asid(e_asid), .e_mask(e_mask), .e_glob(e_glob),
    .vpn(lk_vaddr[VPN_LSB +: VPN_W]), .asid(lk_asid),
    .hit(lk_match), .idx(lk_idx)
  );

  assign rd_ent  = ents[slot_q[IW-1:0]];
  assign lk_ent  = ents[lk_idx];
  assign lk_odd  = odd_pick(lk_vaddr, lk_ent.mask);
  assign lk_half = lk_odd ? lk_ent.odd : lk_ent.even;

  always_comb begin
    lk_hit   = lk_match;
    lk_valid = lk_match & lk_half.valid;
    lk_dirty = lk_match & lk_half.dirty;
    lk_cattr = lk_match ? lk_half.cattr : '0;
    lk_pfn   = lk_match ? lk_half.pfn   : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      even_q <= '0;
      odd_q  <= '0;
      mask_q <= '0;
      slot_q <= '0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_READ: begin
          tag_q  <= {rd_ent.vpn, {(32-VPN_W-ASID_W){1'b0}}, rd_ent.asid};
          mask_q <= {{(32-VPN_LSB-MASK_W){1'b0}}, rd_ent.mask, {VPN_LSB{1'b0}}};
          even_q <= pack_half(rd_ent.even, rd_ent.glob);
          odd_q  <= pack_half(rd_ent.odd,  rd_ent.glob);
        end
        OP_PROBE: slot_q <= probe_hit ? 32'(probe_idx) : (slot_q | MISS_FLAG);
        default: ;
      endcase
    end else if (reg_we) begin
      case (reg_sel)
        SEL_TAG:  tag_q  <= reg_wdata & TAG_KEEP;
        SEL_EVEN: even_q <= reg_wdata & HALF_KEEP;
        SEL_ODD:  odd_q  <= reg_wdata & HALF_KEEP;
        SEL_MASK: mask_q <= reg_wdata & MASK_KEEP;
        SEL_SLOT: slot_q <= reg_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sw_tlb_chk.sv
module sw_tlb_chk #(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic          reg_we,
  input logic [2:0]    reg_sel,
  input logic [31:0]   even_q,
  input logic [31:0]   slot_q,
  input logic [IW-1:0] victim_q,
  input logic          probe_hit,
  input logic [IW-1:0] probe_idx,
  input logic          lk_hit,
  input logic          lk_valid,
  input logic          lk_dirty,
  input logic [2:0]    lk_cattr,
  input logic [19:0]   lk_pfn
);
  localparam logic [IW-1:0] TOP = IW'(ENTRIES - 1);

  AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_q != '0) |=> (victim_q == $past(victim_q) - 1'b1)); // R2
  AST_VICTIM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_q == '0) |=> (victim_q == TOP)); // R2
  AST_PROBE_HIT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3 && probe_hit) |=> (slot_q == 32'($past(probe_idx)))); // R7
  AST_PROBE_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3 && !probe_hit) |=>
      (slot_q[31] && slot_q[30:0] == $past(slot_q[30:0]))); // R8
  AST_REG_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3 && reg_we && reg_sel == 3'd1) |=> $stable(even_q)); // R3
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_valid && !lk_dirty && lk_cattr == '0 && lk_pfn == '0)); // R11
endmodule

bind sw_tlb sw_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .reg_we(reg_we), .reg_sel(reg_sel), .even_q(even_q), .slot_q(slot_q),
  .victim_q(victim_q), .probe_hit(probe_hit), .probe_idx(probe_idx),
  .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
  .lk_cattr(lk_cattr), .lk_pfn(lk_pfn)
);

// File: tb/sw_tlb_test.sv
module sw_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [31:0] tag_q, even_q, odd_q, mask_q, slot_q;
  logic [3:0]  victim_q;
  logic        lk_hit, lk_valid, lk_dirty;
  logic [2:0]  lk_cattr;
  logic [19:0] lk_pfn;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sw_tlb #(.ENTRIES(16)) uut (.*);

  // {vaddr, asid, hit, valid, dirty, cattr, pfn}
  localparam logic [65:0] LK_VEC [11] = '{
    {32'h0040_0000, 8'h05, 1'b1, 1'b1, 1'b1, 3'd3, 20'h00111},
    {32'h0040_1000, 8'h05, 1'b1, 1'b1, 1'b0, 3'd0, 20'h00222},
    {32'h0040_0ABC, 8'h06, 1'b1, 1'b1, 1'b0, 3'd0, 20'h00777},
    {32'h0080_1FFF, 8'h55, 1'b1, 1'b1, 1'b1, 3'd5, 20'h00444},
    {32'h0100_0000, 8'h09, 1'b1, 1'b1, 1'b0, 3'd0, 20'h00555},
    {32'h0100_4000, 8'h09, 1'b1, 1'b1, 1'b1, 3'd2, 20'h00666},
    {32'h0100_6000, 8'h09, 1'b1, 1'b1, 1'b1, 3'd2, 20'h00666},
    {32'h0100_2000, 8'h09, 1'b1, 1'b1, 1'b0, 3'd0, 20'h00555},
    {32'h0100_8000, 8'h09, 1'b0, 1'b0, 1'b0, 3'd0, 20'h00000},
    {32'h0100_0000, 8'h08, 1'b0, 1'b0, 1'b0, 3'd0, 20'h00000},
    {32'h0040_2000, 8'h05, 1'b0, 1'b0, 1'b0, 3'd0, 20'h00000}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] s, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic command(input logic [1:0] op);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic stage(input logic [31:0] hi, input logic [31:0] e, input logic [31:0] o,
                       input logic [31:0] pm);
    reg_write(3'd0, hi);
    reg_write(3'd1, e);
    reg_write(3'd2, o);
    reg_write(3'd3, pm);
  endtask

  task automatic put_slot(input logic [31:0] s, input logic [31:0] hi, input logic [31:0] e,
                          input logic [31:0] o, input logic [31:0] pm);
    stage(hi, e, o, pm);
    reg_write(3'd4, s);
    command(2'd0);
  endtask

  task automatic probe(input logic [31:0] hi, input logic [31:0] exp, input string tag);
    reg_write(3'd0, hi);
    command(2'd3);
    chk(tag, 64'(slot_q), 64'(exp));
  endtask

  task automatic read_slot(input logic [31:0] s, input logic [31:0] ehi, input logic [31:0] ee,
                           input logic [31:0] eo, input logic [31:0] epm);
    reg_write(3'd4, s);
    command(2'd2);
    chk("R6 tag", 64'(tag_q), 64'(ehi));
    chk("R5 even", 64'(even_q), 64'(ee));
    chk("R5 odd", 64'(odd_q), 64'(eo));
    chk("R6 mask", 64'(mask_q), 64'(epm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] saved;
    logic [3:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, before any active edge out of reset
    chk("R1 slot", 64'(slot_q), 64'h0);
    chk("R1 victim", 64'(victim_q), 64'hF);
    lk_vaddr = 32'h0; lk_asid = 8'h0; #1;
    chk("R1 valid", 64'(lk_valid), 64'h0);
    lk_vaddr = 32'h0040_0000; lk_asid = 8'h05; #1;
    chk("R1 empty", 64'({lk_hit, lk_valid}), 64'h0);
    @(negedge clk);

    // R2 victim counter sequence including wrap
    for (int i = 0; i < 20; i++) begin
      r = victim_q;
      @(negedge clk);
      chk("R2 step", 64'(victim_q), 64'(4'(r - 4'd1)));
    end

    // R3 field retention
    reg_write(3'd0, 32'hFFFF_FFFF); chk("R3 tag keep", 64'(tag_q), 64'hFFFF_E0FF);
    reg_write(3'd1, 32'hFFFF_FFFF); chk("R3 half keep", 64'(even_q), 64'h03FF_FFFF);
    reg_write(3'd3, 32'hFFFF_FFFF); chk("R3 mask keep", 64'(mask_q), 64'h01FF_E000);
    reg_write(3'd4, 32'hFFFF_FFFF); chk("R3 slot keep", 64'(slot_q), 64'hFFFF_FFFF);

    // Fill entries (R4 indexed write, R5 global AND)
    put_slot(32'd2, 32'h0040_0005, 32'h0000_445F, 32'h0000_8882, 32'h0);
    put_slot(32'd5, 32'h0080_0007, 32'h0000_CCC3, 32'h0001_112F, 32'h0);
    put_slot(32'd7, 32'h0100_0009, 32'h0001_5542, 32'h0001_9996, 32'h0000_6000);
    put_slot(32'd9, 32'h0040_0005, 32'h0001_DDC3, 32'h0002_2203, 32'h0);

    // R6 read back
    read_slot(32'd2, 32'h0040_0005, 32'h0000_445E, 32'h0000_8882, 32'h0);
    read_slot(32'd5, 32'h0080_0007, 32'h0000_CCC3, 32'h0001_112F, 32'h0);
    read_slot(32'd7, 32'h0100_0009, 32'h0001_5542, 32'h0001_9996, 32'h0000_6000);

    // R7 / R8 probes
    probe(32'h0040_0005, 32'd2, "R7 lowest slot");
    probe(32'h0040_0006, 32'd9, "R7 global");
    probe(32'h0080_0099, 32'd5, "R7 global other id");
    probe(32'h00A0_0005, 32'h8000_0005, "R8 miss keeps bits");
    // R3 register write ignored when a command is issued
    reg_write(3'd0, 32'h0100_0009);
    saved = even_q;
    reg_we = 1'b1; reg_sel = 3'd1; reg_wdata = 32'h0000_DEAD;
    command(2'd3);
    reg_we = 1'b0;
    chk("R3 ignored", 64'(even_q), 64'(saved));
    chk("R7 clears flag", 64'(slot_q), 64'd7);
    probe(32'h0100_000A, 32'h8000_0007, "R8 id mismatch");

    // R9 R10 R11 lookup table
    for (int i = 0; i < 11; i++) begin
      lk_vaddr = LK_VEC[i][65:34];
      lk_asid  = LK_VEC[i][33:26];
      #1;
      chk($sformatf("R9 R10 R11 vector %0d", i),
          64'({lk_hit, lk_valid, lk_dirty, lk_cattr, lk_pfn}), 64'(LK_VEC[i][25:0]));
    end
    @(negedge clk);

    // R4 indexed write drops high slot bits
    put_slot(32'h0000_0013, 32'h0300_0001, 32'h0002_6642, 32'h0000_0002, 32'h0);
    probe(32'h0300_0001, 32'd3, "R4 slot wrap");
    command(2'd2);
    chk("R4 slot content", 64'(even_q), 64'h0002_6642);

    // R4 victim write uses the counter value at that edge
    stage(32'h0200_0003, 32'h0002_AF02, 32'h0000_0002, 32'h0);
    while (victim_q !== 4'd12) @(negedge clk);
    command(2'd1);
    probe(32'h0200_0003, 32'd12, "R4 victim slot");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule